// File: doc/BRIEF.md
# Stereo Soft-Mute Gain Ramp

This block fades a two-channel stream of 24-bit signed samples in and out by applying a gain that moves one step per output frame. The gain is a count from 0 (silence) to 1024 (unity). A sample is scaled by multiplying it by the count, adding half of one unit and shifting right arithmetically by ten bits. One step per frame makes a full fade take exactly 1024 frames.

Two behaviours are selected while the block is held in power-down. In manual mode a mute request drives the gain toward zero, and releasing the request drives it back toward unity. The ramp reverses from whatever level it has reached. In auto-recovery mode the mute request has no effect. After power-down ends, the output stays silent for a fixed hold of 4410 frames and then rises to unity over 1024 frames. A flag reports when the gain is exactly zero.

Top module: `smute_top`

## Requirements
- R1: While `pdn_n` is low, both sample outputs are zero and `muted` is high on the clock after `pdn_n` was sampled low. The gain restarts from zero when `pdn_n` returns high.
- R2: In manual mode, a strobe taken with `mute_req` high lowers the gain by one. From unity, the 1024th such strobe gives zero output.
- R3: In manual mode, a strobe taken with `mute_req` low raises the gain by one. At a gain of 1024 the output equals the input exactly.
- R4: A change of `mute_req` during a ramp reverses the direction from the gain already reached, with no jump.
- R5: In auto-recovery mode (`mode_auto`=1 during power-down), the first 4410 strobes after power-down give zero output. Each later strobe raises the gain by one until unity, whatever the value of `mute_req`.
- R6: On each strobe, each output becomes floor((sample*gain + 512) / 1024), using the gain after that strobe's step. Samples are two's complement.
- R7: `muted` is high exactly when the gain is zero.
- R8: `mode_auto` is captured only while `pdn_n` is low. Changes of `mode_auto` while the block runs have no effect.
- R9: Without a strobe, the gain and both outputs hold their values, even if the inputs change.
- R10: The gain does not rise above 1024 or fall below 0. Extra strobes at either end leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pdn_n | input | 1 | Power-down, active low. Acts as a synchronous reset. |
| mode_auto | input | 1 | 1 = auto-recovery mode, 0 = manual mode. Captured during power-down only. |
| mute_req | input | 1 | Mute request, used in manual mode |
| frame_stb | input | 1 | One-cycle pulse per output frame |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_left | output | 24 | Attenuated left sample |
| out_right | output | 24 | Attenuated right sample |
| muted | output | 1 | High when the gain is zero |

## Verification
The gain and both sample outputs are registered on the clock edge that samples `frame_stb`. Each frame's result is therefore due one clock after the strobe is presented, and `muted` follows in the same cycle because it decodes the registered gain. The bench drives the strobe, the mute request and the samples on a falling edge and reads the results on the next falling edge. This places every check half a cycle after the update it observes. The hold-off count is checked frame by frame. The outputs must be zero at strobe 4410 and must show gain 1 at strobe 4411, so the hold-off is confirmed to the exact frame.

// File: rtl/smute_pkg.sv
package smute_pkg;

  typedef enum logic {
    MODE_MANUAL = 1'b0,
    MODE_AUTO   = 1'b1
  } sm_mode_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10
  } sm_dir_e;

endpackage

// File: rtl/smute_gain_ctrl.sv
module smute_gain_ctrl
  import smute_pkg::*;
#(
  parameter int FRAC_BITS   = 10,
  parameter int HOLD_FRAMES = 4410,
  localparam int UNITY      = 1 << FRAC_BITS,
  localparam int GAIN_W     = FRAC_BITS + 1,
  localparam int HOLD_W     = $clog2(HOLD_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              pdn_n,
  input  logic              mode_auto,
  input  logic              mute_req,
  input  logic              frame_stb,
  output logic [GAIN_W-1:0] gain_q,
  output logic [GAIN_W-1:0] gain_nxt,
  output sm_mode_e          mode_q,
  output logic              hold_active,
  output logic              step_up,
  output logic              step_down
);

  logic [HOLD_W-1:0] hold_cnt;
  sm_dir_e           dir;
  logic              at_top;
  logic              at_floor;

  assign at_top   = (gain_q == GAIN_W'(UNITY));
  assign at_floor = (gain_q == '0);

  // Hold-off only exists in auto-recovery mode
  assign hold_active = (mode_q == MODE_AUTO) && (hold_cnt < HOLD_W'(HOLD_FRAMES));

  always_comb begin
    if (hold_active)                dir = DIR_HOLD;
    else if (mode_q == MODE_AUTO)   dir = DIR_UP;
    else if (mute_req)              dir = DIR_DOWN;
    else                            dir = DIR_UP;
  end

  assign step_up   = frame_stb && (dir == DIR_UP)   && !at_top;
  assign step_down = frame_stb && (dir == DIR_DOWN) && !at_floor;

  always_comb begin
    gain_nxt = gain_q;
    if (step_up)        gain_nxt = gain_q + GAIN_W'(1);
    else if (step_down) gain_nxt = gain_q - GAIN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!pdn_n) begin
      gain_q   <= '0;
      hold_cnt <= '0;
      mode_q   <= mode_auto ? MODE_AUTO : MODE_MANUAL;
    end else begin
      gain_q <= gain_nxt;
      if (frame_stb && hold_active) hold_cnt <= hold_cnt + HOLD_W'(1);
    end
  end

endmodule

// File: rtl/smute_scaler.sv
module smute_scaler #(
  parameter int DATA_W    = 24,
  parameter int FRAC_BITS = 10,
  localparam int GAIN_W   = FRAC_BITS + 1,
  localparam int PROD_W   = DATA_W + GAIN_W + 1,
  localparam int ROUND    = 1 << (FRAC_BITS - 1)
) (
  input  logic                     clk,
  input  logic                     pdn_n,
  input  logic                     frame_stb,
  input  logic [GAIN_W-1:0]        gain,
  input  logic signed [DATA_W-1:0] smp_in,
  output logic signed [DATA_W-1:0] smp_out
);

  // Multiply by gain, add half a unit, arithmetic shift (floor)
  function automatic logic signed [DATA_W-1:0] apply_gain(
    input logic signed [DATA_W-1:0] s,
    input logic [GAIN_W-1:0]        g
  );
    logic signed [PROD_W-1:0] p;
    logic signed [PROD_W-1:0] q;
    p = PROD_W'(s) * $signed({1'b0, g});
    p = p + $signed(PROD_W'(ROUND));
    q = p >>> FRAC_BITS;
    return q[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!pdn_n)         smp_out <= '0;
    else if (frame_stb) smp_out <= apply_gain(smp_in, gain);
  end

endmodule

// File: rtl/smute_top.sv
module smute_top
  import smute_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int FRAC_BITS   = 10,
  parameter int HOLD_FRAMES = 4410
) (
  input  logic              clk,
  input  logic              pdn_n,
  input  logic              mode_auto,
  input  logic              mute_req,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              muted
);

  localparam int GAIN_W = FRAC_BITS + 1;
  localparam int NUM_CH = 2;

  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] gain_nxt;
  sm_mode_e          mode_q;
  logic              hold_active;
  logic              step_up;
  logic              step_down;

  logic signed [DATA_W-1:0] ch_in  [NUM_CH];
  logic signed [DATA_W-1:0] ch_out [NUM_CH];

  smute_gain_ctrl #(
    .FRAC_BITS  (FRAC_BITS),
    .HOLD_FRAMES(HOLD_FRAMES)
  ) u_gain (
    .clk        (clk),
    .pdn_n      (pdn_n),
    .mode_auto  (mode_auto),
    .mute_req   (mute_req),
    .frame_stb  (frame_stb),
    .gain_q     (gain_q),
    .gain_nxt   (gain_nxt),
    .mode_q     (mode_q),
    .hold_active(hold_active),
    .step_up    (step_up),
    .step_down  (step_down)
  );

  assign ch_in[0] = $signed(in_left);
  assign ch_in[1] = $signed(in_right);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    smute_scaler #(
      .DATA_W   (DATA_W),
      .FRAC_BITS(FRAC_BITS)
    ) u_scl (
      .clk      (clk),
      .pdn_n    (pdn_n),
      .frame_stb(frame_stb),
      .gain     (gain_nxt),
      .smp_in   (ch_in[c]),
      .smp_out  (ch_out[c])
    );
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];
  assign muted     = (gain_q == '0);

endmodule

// File: rtl/smute_chk.sv
module smute_chk #(
  parameter int DATA_W    = 24,
  parameter int FRAC_BITS = 10,
  localparam int GAIN_W   = FRAC_BITS + 1,
  localparam int UNITY    = 1 << FRAC_BITS
) (
  input logic              clk,
  input logic              pdn_n,
  input logic              mode_auto,
  input logic              mute_req,
  input logic              frame_stb,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              muted,
  input logic [GAIN_W-1:0] gain,
  input logic              mode_q,
  input logic              hold_active
);

  logic rst_prev = 1'b0;

  always_ff @(posedge clk) begin
    rst_prev <= !pdn_n;
    if (rst_prev) begin
      AST_RESET_SILENT: assert (out_left == '0 && out_right == '0 && muted)
        else $error("outputs not silent after power-down"); // R1
    end
  end

  AST_FALL_STEP: assert property (@(posedge clk) disable iff (!pdn_n)
    frame_stb && !mode_q && mute_req && gain != '0 |=> gain == $past(gain) - GAIN_W'(1)); // R2

  AST_RISE_STEP: assert property (@(posedge clk) disable iff (!pdn_n)
    frame_stb && !mode_q && !mute_req && gain != GAIN_W'(UNITY) |=> gain == $past(gain) + GAIN_W'(1)); // R3

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!pdn_n)
    hold_active |-> gain == '0); // R5

  AST_AUTO_NO_FALL: assert property (@(posedge clk) disable iff (!pdn_n)
    frame_stb && mode_q |=> gain >= $past(gain)); // R5

  AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (!pdn_n)
    muted |-> out_left == '0 && out_right == '0); // R7

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!pdn_n)
    $past(pdn_n) |-> $stable(mode_q)); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!pdn_n)
    !frame_stb |=> $stable(gain) && $stable(out_left) && $stable(out_right)); // R9

  AST_GAIN_LIMIT: assert property (@(posedge clk) disable iff (!pdn_n)
    gain <= GAIN_W'(UNITY)); // R10

endmodule

bind smute_top smute_chk #(
  .DATA_W   (DATA_W),
  .FRAC_BITS(FRAC_BITS)
) u_chk (
  .clk        (clk),
  .pdn_n      (pdn_n),
  .mode_auto  (mode_auto),
  .mute_req   (mute_req),
  .frame_stb  (frame_stb),
  .out_left   (out_left),
  .out_right  (out_right),
  .muted      (muted),
  .gain       (gain_q),
  .mode_q     (mode_q),
  .hold_active(hold_active)
);

// File: tb/tb_smute_top.sv
module tb_smute_top;

  localparam int W     = 24;
  localparam int UNITY = 1024;
  localparam int HOLD  = 4410;

  logic         clk = 1'b0;
  logic         pdn_n = 1'b0;
  logic         mode_auto = 1'b0;
  logic         mute_req = 1'b0;
  logic         frame_stb = 1'b0;
  logic [W-1:0] in_left = '0;
  logic [W-1:0] in_right = '0;
  logic [W-1:0] out_left;
  logic [W-1:0] out_right;
  logic         muted;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the gain
  int m_gain = 0;
  int m_hold = 0;
  bit m_auto = 0;

  always #4 clk = ~clk;

  smute_top dut (
    .clk      (clk),
    .pdn_n    (pdn_n),
    .mode_auto(mode_auto),
    .mute_req (mute_req),
    .frame_stb(frame_stb),
    .in_left  (in_left),
    .in_right (in_right),
    .out_left (out_left),
    .out_right(out_right),
    .muted    (muted)
  );

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  // floor((s*g + 512)/1024) written via division and correction
  function automatic int scaled(input int s, input int g);
    longint num;
    longint q;
    num = longint'(s) * g + 512;
    q   = num / 1024;
    if (num < 0 && (num % 1024) != 0) q = q - 1;
    return int'(q);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit auto_m);
    @(negedge clk);
    pdn_n = 1'b0;
    mode_auto = auto_m;
    repeat (3) @(negedge clk);
    pdn_n = 1'b1;
    m_gain = 0;
    m_hold = 0;
    m_auto = auto_m;
  endtask

  // one frame: strobe, then compare at next falling edge
  task automatic frame(input string req, input bit mreq, input int l, input int r);
    @(negedge clk);
    mute_req  = mreq;
    in_left   = W'(l);
    in_right  = W'(r);
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    if (m_auto) begin
      if (m_hold < HOLD) m_hold++;
      else if (m_gain < UNITY) m_gain++;
    end else if (mreq) begin
      if (m_gain > 0) m_gain--;
    end else if (m_gain < UNITY) begin
      m_gain++;
    end
    check(req, sx(out_left), scaled(l, m_gain));
    check(req, sx(out_right), scaled(r, m_gain));
    check({req, " muted flag R7"}, int'(muted), int'(m_gain == 0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    pdn_n = 1'b0;
    frame_stb = 1'b1;
    in_left = 24'h3FFFFF;
    in_right = 24'h400000;
    repeat (2) @(negedge clk);
    frame_stb = 1'b0;
    check("R1 left", sx(out_left), 0);
    check("R1 right", sx(out_right), 0);
    check("R1 muted", int'(muted), 1);
  endtask

  task automatic t_fade_in();
    for (int i = 0; i < UNITY; i++) frame("R3 fade in", 1'b0, 4194304, -3000001);
    frame("R3 unity left", 1'b0, 8388607, -8388608);
    check("R3 unity exact", sx(out_left), 8388607);
    frame("R10 top limit", 1'b0, -77, 12345);
    check("R10 top exact", sx(out_right), 12345);
  endtask

  task automatic t_idle();
    int l0;
    int r0;
    l0 = sx(out_left);
    r0 = sx(out_right);
    @(negedge clk);
    in_left = 24'h123456;
    in_right = 24'hABCDEF;
    mute_req = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 left held", sx(out_left), l0);
    check("R9 right held", sx(out_right), r0);
    mute_req = 1'b0;
  endtask

  task automatic t_fade_out();
    for (int i = 0; i < UNITY - 1; i++) frame("R2 fade out", 1'b1, 8388607, -1234567);
    check("R7 not yet muted", int'(muted), 0);
    frame("R2 last step", 1'b1, 8388607, -1234567);
    check("R2 silent", sx(out_left), 0);
    check("R7 muted at zero", int'(muted), 1);
    frame("R10 floor limit", 1'b1, 5000000, -5000000);
    check("R10 floor silent", sx(out_right), 0);
  endtask

  task automatic t_reverse();
    for (int i = 0; i < 300; i++) frame("R4 up", 1'b0, i * 7919 - 4000000, 3 - i * 1031);
    for (int i = 0; i < 100; i++) frame("R4 down", 1'b1, -i * 5 - 1, i * 40961 + 7);
    frame("R4 turn", 1'b0, 1000000, -1000000);
    check("R4 level 201", sx(out_left), scaled(1000000, 201));
    for (int i = 0; i < 40; i++) frame("R6 rounding", 1'b0, -511 - i * 3, 1535 + i);
  endtask

  task automatic t_auto();
    do_reset(1'b1);
    @(negedge clk);
    mode_auto = 1'b0;
    for (int i = 0; i < HOLD; i++) frame("R5 hold", i[0], 4194304, -4194304);
    check("R5 hold silent", sx(out_left), 0);
    check("R8 mode kept", int'(muted), 1);
    frame("R5 first step", 1'b1, 4194304, -4194304);
    check("R5 gain one", sx(out_left), 4096);
    for (int i = 0; i < UNITY - 1; i++) frame("R5 ramp ignores mute", 1'b1, 2097151, -2097152);
    check("R5 unity", sx(out_left), 2097151);
    frame("R8 still auto", 1'b1, 100, -100);
    check("R8 mute ignored", sx(out_right), -100);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset();
    do_reset(1'b0);
    t_fade_in();
    t_idle();
    t_fade_out();
    t_reverse();
    t_auto();
    t_reset();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule